// File: doc/BRIEF.md
# Interrupt Pending and Mask Unit

This block keeps the pending and enable state for a small processor interrupt controller. Eight external pins and two timer pulses post requests into a ten-bit pending register. Each pin can be set up for edge or level detection. A ten-bit mask register picks which posted requests may interrupt the core. The unit reduces the enabled pending bits to one request line and to the index of the highest-numbered candidate. When the core accepts an interrupt, it signals an acknowledge. On a hardware acknowledge the unit clears the pending bit of that source, and it can also clear the whole mask if configured to.

Software reaches both registers through a single-cycle request port that supports plain reads, plain writes and an atomic bit-masked modify. Read data comes back one clock after the request. A modify that lands in the same cycle as a pin, timer or acknowledge event wins that cycle. The event is held and applied in the following cycle, so it never splits the modify.

Three operating modes set which bits are meaningful. In the two modes that share the pins with an external vectored bus, mask bit 0 becomes a global enable for that bus.

Top module: `intc_pend_mask`

## Requirements
- R1: After reset the pending and mask registers read zero, and `irq_req`, `rd_valid` and `xirq_en` are low.
- R2: With `cfg_level[i]`=0, a rising edge on `ext_pin[i]` passes a two-stage synchronizer and sets pending bit i. The bit is set two clocks after the edge that first samples the pin high, and it stays set after the pin falls.
- R3: With `cfg_level[i]`=1, pending bit i is set on every cycle its synchronized level is high. A hardware acknowledge of i while that level is still high leaves the bit set. Once the level has gone low, the acknowledge clears it.
- R4: A one-cycle pulse on `tmr_pulse[j]` sets pending bit 8+j at the next clock edge.
- R5: Pending bits outside the active mode's range are changed by neither sources nor software. In mixed mode (`cfg_mode`=1) these are bits 0–4. In expanded mode (`cfg_mode`=2) they are bits 0–7. Dedicated mode (`cfg_mode`=0) uses all ten bits.
- R6: `irq_req` is high when any valid pending bit has its mask bit at 1. `irq_idx` then gives the highest such bit index.
- R7: Mask bits 1–4 in mixed mode and 1–7 in expanded mode read as zero and store zero when written.
- R8: In mixed and expanded modes `xirq_en` follows mask bit 0. In dedicated mode `xirq_en` is low and mask bit 0 gates pin 0.
- R9: A hardware acknowledge (`ack_type`=0) clears the whole mask register only when `cfg_mask_clr`=1. An NMI (`ack_type`=1) or software (`ack_type`=2) acknowledge never changes the mask.
- R10: A hardware acknowledge clears pending bit `ack_idx` of an edge-detected or timer source.
- R11: Register port encoding: `req_op` 0 = read, 1 = write, 2 = atomic; `req_sel` 0 = pending, 1 = mask. An atomic access returns the old value and stores (old & ~`req_wmask`) | (`req_wdata` & `req_wmask`). A bit set this way posts an interrupt exactly like a pin.
- R12: When a write or atomic on a register coincides with a source, acknowledge or mask-clear event on the same register, the register first takes the written value. The event is applied in the following cycle.
- R13: Read data appears with `rd_valid` one clock after a read or atomic request. A write is visible to an access issued in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | 0 dedicated, 1 mixed, 2 expanded |
| cfg_level | input | 8 | Per-pin level (1) or edge (0) detection |
| cfg_mask_clr | input | 1 | Clear mask on hardware acknowledge |
| ext_pin | input | 8 | Asynchronous external request pins |
| tmr_pulse | input | 2 | Synchronous timer request pulses |
| req_valid | input | 1 | Register access strobe |
| req_op | input | 2 | Access kind |
| req_sel | input | 1 | Register select |
| req_wdata | input | 10 | Write data |
| req_wmask | input | 10 | Bit mask for atomic access |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 10 | Read data |
| ack_valid | input | 1 | Core acknowledge strobe |
| ack_type | input | 2 | 0 hardware, 1 NMI, 2 software |
| ack_idx | input | 4 | Acknowledged source index |
| irq_req | output | 1 | Interrupt request to the core |
| irq_idx | output | 4 | Highest enabled pending index |
| xirq_en | output | 1 | Global enable for the external vectored bus |

## Verification
The bench targets the corner cases where a careless design diverges.

It lands a timer pulse in the same cycle as an atomic that clears that bit. A design that lets the event win would raise the request one cycle early. A design that drops the event would never raise it.

It issues a hardware acknowledge with mask clearing in the same cycle as an atomic write to the mask. A design that merges the two in the wrong order shows the wrong request for one cycle.

It acknowledges a level source while the pin is still high. A design that clears the bit unconditionally would drop the request.

It writes ones into reserved pending and mask bits in the mixed and expanded modes, and toggles pins that are reserved there. A design that ignores the mode would read those ones back.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DEF_N_PIN = 8;
  localparam int DEF_N_TMR = 2;

  typedef enum logic [1:0] {
    MODE_DED = 2'd0,
    MODE_MIX = 2'd1,
    MODE_EXP = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_ATM = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    ACK_HW  = 2'd0,
    ACK_NMI = 2'd1,
    ACK_SW  = 2'd2
  } ack_e;

  localparam logic SEL_PEND = 1'b0;
  localparam logic SEL_MASK = 1'b1;
endpackage

// File: rtl/intc_mode_dec.sv
module intc_mode_dec #(
  parameter int N_SRC  = 10,
  parameter int MIX_LO = 5,
  parameter int EXP_LO = 8
) (
  input  logic [1:0]       mode_i,
  output logic [N_SRC-1:0] pend_ok_o,
  output logic [N_SRC-1:0] mask_ok_o,
  output logic             ext_glob_o
);
  import intc_pkg::*;

  // valid pending bits per mode; mask bit 0 always kept
  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      case (mode_i)
        MODE_MIX: pend_ok_o[i] = (i >= MIX_LO);
        MODE_EXP: pend_ok_o[i] = (i >= EXP_LO);
        default:  pend_ok_o[i] = 1'b1;
      endcase
    end
  end

  assign mask_ok_o  = pend_ok_o | N_SRC'(1);
  assign ext_glob_o = (mode_i == MODE_MIX) || (mode_i == MODE_EXP);
endmodule

// File: rtl/intc_src_detect.sv
module intc_src_detect #(
  parameter int N_PIN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_PIN-1:0] pin_i,
  input  logic [N_PIN-1:0] level_cfg_i,
  output logic [N_PIN-1:0] set_o
);
  logic [N_PIN-1:0] sync1_q, sync2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  for (genvar g = 0; g < N_PIN; g++) begin : g_pin
    assign set_o[g] = level_cfg_i[g] ? sync2_q[g] : (sync2_q[g] & ~prev_q[g]);
  end
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
  parameter int N  = 10,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = |vec_i;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/intc_pend_mask.sv
module intc_pend_mask #(
  parameter int N_PIN  = intc_pkg::DEF_N_PIN,
  parameter int N_TMR  = intc_pkg::DEF_N_TMR,
  parameter int MIX_LO = 5,
  localparam int N_SRC = N_PIN + N_TMR,
  localparam int IW    = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mode,
  input  logic [N_PIN-1:0] cfg_level,
  input  logic             cfg_mask_clr,
  input  logic [N_PIN-1:0] ext_pin,
  input  logic [N_TMR-1:0] tmr_pulse,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic             req_sel,
  input  logic [N_SRC-1:0] req_wdata,
  input  logic [N_SRC-1:0] req_wmask,
  output logic             rd_valid,
  output logic [N_SRC-1:0] rd_data,
  input  logic             ack_valid,
  input  logic [1:0]       ack_type,
  input  logic [IW-1:0]    ack_idx,
  output logic             irq_req,
  output logic [IW-1:0]    irq_idx,
  output logic             xirq_en
);
  import intc_pkg::*;

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic [N_SRC-1:0] pend_q, pend_n, mask_q, mask_n;
  logic [N_SRC-1:0] hset_q, hset_n, hclr_q, hclr_n;
  logic             hmclr_q, hmclr_n;
  logic [N_SRC-1:0] pend_ok, mask_ok, src_set, ack_vec;
  logic [N_SRC-1:0] cur_val, upd_val, rd_n;
  logic [N_PIN-1:0] pin_set;
  logic             ext_glob, pend_wr, mask_wr, ack_hw, mclr_now, rd_en;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  intc_mode_dec #(.N_SRC(N_SRC), .MIX_LO(MIX_LO), .EXP_LO(N_PIN)) u_dec (
    .mode_i(cfg_mode), .pend_ok_o(pend_ok), .mask_ok_o(mask_ok), .ext_glob_o(ext_glob)
  );

  intc_src_detect #(.N_PIN(N_PIN)) u_det (
    .clk(clk), .rst_n(rst_int_n), .pin_i(ext_pin), .level_cfg_i(cfg_level), .set_o(pin_set)
  );

  intc_prio_pick #(.N(N_SRC)) u_pick (
    .vec_i(pend_q & mask_q & pend_ok & mask_ok), .any_o(irq_req), .idx_o(irq_idx)
  );

  assign xirq_en = ext_glob & mask_q[0];

  // decode of the access and acknowledge
  assign pend_wr  = req_valid && (req_sel == SEL_PEND) && (req_op != OP_RD);
  assign mask_wr  = req_valid && (req_sel == SEL_MASK) && (req_op != OP_RD);
  assign ack_hw   = ack_valid && (ack_type == ACK_HW);
  assign mclr_now = ack_hw && cfg_mask_clr;
  assign rd_en    = req_valid && (req_op != OP_WR);
  assign src_set  = {tmr_pulse, pin_set} & pend_ok;

  always_comb begin
    ack_vec = '0;
    if (ack_hw && (32'(ack_idx) < N_SRC)) ack_vec[ack_idx] = 1'b1;
    ack_vec = ack_vec & pend_ok;
  end

  always_comb begin
    cur_val = (req_sel == SEL_MASK) ? (mask_q & mask_ok) : pend_q;
    upd_val = (req_op == OP_ATM) ? ((cur_val & ~req_wmask) | (req_wdata & req_wmask))
                                 : req_wdata;
    rd_n    = cur_val;
  end

  // next state: a register access wins its cycle, events are held one cycle
  always_comb begin
    pend_n  = pend_q;
    hset_n  = '0;
    hclr_n  = '0;
    if (pend_wr) begin
      pend_n = (pend_q & ~pend_ok) | (upd_val & pend_ok);
      hset_n = hset_q | src_set;
      hclr_n = hclr_q | ack_vec;
    end else begin
      pend_n = (pend_q & ~((hclr_q | ack_vec) & pend_ok)) | ((hset_q | src_set) & pend_ok);
    end

    mask_n  = mask_q;
    hmclr_n = 1'b0;
    if (mask_wr) begin
      mask_n  = upd_val & mask_ok;
      hmclr_n = hmclr_q | mclr_now;
    end else if (hmclr_q || mclr_now) begin
      mask_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pend_q   <= '0;
      mask_q   <= '0;
      hset_q   <= '0;
      hclr_q   <= '0;
      hmclr_q  <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      pend_q   <= pend_n;
      mask_q   <= mask_n;
      hset_q   <= hset_n;
      hclr_q   <= hclr_n;
      hmclr_q  <= hmclr_n;
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_n;
    end
  end
endmodule

// File: rtl/intc_pend_mask_chk.sv
module intc_pend_mask_chk #(
  parameter int N_SRC  = 10,
  parameter int IW     = 4,
  parameter int EXP_LO = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cfg_mode,
  input logic             cfg_mask_clr,
  input logic             req_valid,
  input logic [1:0]       req_op,
  input logic             req_sel,
  input logic [N_SRC-1:0] req_wdata,
  input logic [N_SRC-1:0] req_wmask,
  input logic             rd_valid,
  input logic             ack_valid,
  input logic [1:0]       ack_type,
  input logic             irq_req,
  input logic [IW-1:0]    irq_idx,
  input logic [N_SRC-1:0] pend_q,
  input logic [N_SRC-1:0] mask_q,
  input logic [N_SRC-1:0] pend_ok,
  input logic             hmclr_q
);
  // R13
  read_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op != 2'd1) |=> rd_valid);

  // R6
  irq_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (pend_q[irq_idx] && mask_q[irq_idx]));

  // R5
  exp_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd2) |=> $stable(pend_q[EXP_LO-1:0]));

  // R9
  nmi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_type != 2'd0 && !hmclr_q && !(req_valid && req_sel && req_op != 2'd0))
      |=> $stable(mask_q));

  // R9
  hw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_type == 2'd0 && cfg_mask_clr && !(req_valid && req_sel && req_op != 2'd0))
      |=> (mask_q == '0));

  // R12
  atom_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_sel && req_op == 2'd2)
      |=> (((pend_q ^ $past(req_wdata)) & $past(req_wmask) & $past(pend_ok)) == '0));
endmodule

bind intc_pend_mask intc_pend_mask_chk u_chk (
  .clk(clk), .rst_n(rst_int_n), .cfg_mode(cfg_mode), .cfg_mask_clr(cfg_mask_clr),
  .req_valid(req_valid), .req_op(req_op), .req_sel(req_sel), .req_wdata(req_wdata),
  .req_wmask(req_wmask), .rd_valid(rd_valid), .ack_valid(ack_valid), .ack_type(ack_type),
  .irq_req(irq_req), .irq_idx(irq_idx), .pend_q(pend_q), .mask_q(mask_q),
  .pend_ok(pend_ok), .hmclr_q(hmclr_q)
);

// File: tb/sim_intc_pend_mask.sv
module sim_intc_pend_mask;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] cfg_mode;
  logic [7:0] cfg_level;
  logic       cfg_mask_clr;
  logic [7:0] ext_pin;
  logic [1:0] tmr_pulse;
  logic       req_valid;
  logic [1:0] req_op;
  logic       req_sel;
  logic [9:0] req_wdata, req_wmask;
  logic       rd_valid;
  logic [9:0] rd_data;
  logic       ack_valid;
  logic [1:0] ack_type;
  logic [3:0] ack_idx;
  logic       irq_req;
  logic [3:0] irq_idx;
  logic       xirq_en;

  int vectors = 0;
  int errs    = 0;
  logic [9:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  intc_pend_mask u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_level(cfg_level),
    .cfg_mask_clr(cfg_mask_clr), .ext_pin(ext_pin), .tmr_pulse(tmr_pulse),
    .req_valid(req_valid), .req_op(req_op), .req_sel(req_sel), .req_wdata(req_wdata),
    .req_wmask(req_wmask), .rd_valid(rd_valid), .rd_data(rd_data),
    .ack_valid(ack_valid), .ack_type(ack_type), .ack_idx(ack_idx),
    .irq_req(irq_req), .irq_idx(irq_idx), .xirq_en(xirq_en)
  );

  task automatic chk(string tag, int got, int exp);
    vectors++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) begin
        vectors++;
        errs++;
        $display("FAIL R13: unexpected read data 0x%0h expected none", rd_data);
      end else begin
        chk(tag_q.pop_front(), int'(rd_data), int'(exp_q.pop_front()));
      end
    end
  end

  // driver: called at a negedge, returns at the next negedge
  task automatic regop(logic [1:0] op, logic sel, logic [9:0] wd, logic [9:0] wm,
                       logic [9:0] expv, string tag);
    req_valid = 1'b1; req_op = op; req_sel = sel; req_wdata = wd; req_wmask = wm;
    if (op != 2'd1) begin exp_q.push_back(expv); tag_q.push_back(tag); end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic ack(logic [1:0] kind, logic [3:0] idx);
    ack_valid = 1'b1; ack_type = kind; ack_idx = idx;
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic pin_pulse(int i);
    ext_pin[i] = 1'b1;
    @(negedge clk);
    ext_pin[i] = 1'b0;
  endtask

  task automatic irq_is(string tag, logic r, logic [3:0] idx);
    chk(tag, int'(irq_req), int'(r));
    if (r) chk(tag, int'(irq_idx), int'(idx));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_mode = 2'd0; cfg_level = 8'h04; cfg_mask_clr = 1'b0;
    ext_pin = '0; tmr_pulse = '0; req_valid = 1'b0; req_op = 2'd0; req_sel = 1'b0;
    req_wdata = '0; req_wmask = '0; ack_valid = 1'b0; ack_type = 2'd0; ack_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 irq_req", int'(irq_req), 0);
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 xirq_en", int'(xirq_en), 0);
    regop(2'd0, 1'b0, 0, 0, 10'h000, "R1 pending");
    regop(2'd0, 1'b1, 0, 0, 10'h000, "R1 mask");

    // R13 write then read in the next cycle
    regop(2'd1, 1'b1, 10'h3FF, 0, 0, "");
    regop(2'd0, 1'b1, 0, 0, 10'h3FF, "R13 mask readback");
    chk("R8 dedicated xirq_en", int'(xirq_en), 0);

    // R2 edge pin 3
    pin_pulse(3);
    @(negedge clk); irq_is("R2 latency", 1'b0, 0);
    @(negedge clk); irq_is("R2 edge latched", 1'b1, 4'd3);
    repeat (4) @(negedge clk);
    irq_is("R2 held after fall", 1'b1, 4'd3);
    regop(2'd0, 1'b0, 0, 0, 10'h008, "R2 pending");

    // R10 hardware ack clears, mask kept
    ack(2'd0, 4'd3);
    irq_is("R10 ack clears", 1'b0, 0);
    regop(2'd0, 1'b1, 0, 0, 10'h3FF, "R9 mask kept without option");

    // R4 timers and R6 priority
    tmr_pulse[1] = 1'b1; @(negedge clk); tmr_pulse = '0;
    irq_is("R4 timer 1", 1'b1, 4'd9);
    pin_pulse(5); repeat (2) @(negedge clk);
    irq_is("R6 highest wins", 1'b1, 4'd9);
    ack(2'd0, 4'd9);
    irq_is("R6 next candidate", 1'b1, 4'd5);
    ack(2'd0, 4'd5);
    irq_is("R10 all clear", 1'b0, 0);

    // R3 level pin 2
    ext_pin[2] = 1'b1;
    repeat (3) @(negedge clk);
    irq_is("R3 level set", 1'b1, 4'd2);
    ack(2'd0, 4'd2);
    irq_is("R3 stays while high", 1'b1, 4'd2);
    ext_pin[2] = 1'b0;
    repeat (3) @(negedge clk);
    irq_is("R3 latched after low", 1'b1, 4'd2);
    ack(2'd0, 4'd2);
    irq_is("R3 clears when low", 1'b0, 0);

    // R11 atomic software post and R6 masking
    regop(2'd2, 1'b0, 10'h040, 10'h040, 10'h000, "R11 atomic old pending");
    irq_is("R11 software post", 1'b1, 4'd6);
    regop(2'd2, 1'b1, 10'h000, 10'h040, 10'h3FF, "R11 atomic old mask");
    irq_is("R6 masked off", 1'b0, 0);
    regop(2'd2, 1'b1, 10'h040, 10'h040, 10'h3BF, "R11 atomic old mask 2");
    irq_is("R6 unmasked", 1'b1, 4'd6);

    // R9 ack kinds and mask clearing
    cfg_mask_clr = 1'b1;
    ack(2'd1, 4'd6);
    regop(2'd0, 1'b1, 0, 0, 10'h3FF, "R9 NMI keeps mask");
    ack(2'd2, 4'd6);
    regop(2'd0, 1'b1, 0, 0, 10'h3FF, "R9 software keeps mask");
    ack(2'd0, 4'd6);
    irq_is("R10 hw ack", 1'b0, 0);
    regop(2'd0, 1'b1, 0, 0, 10'h000, "R9 hw clears mask");
    regop(2'd0, 1'b0, 0, 0, 10'h000, "R10 pending cleared");
    cfg_mask_clr = 1'b0;

    // R12 timer event coinciding with atomic on pending
    regop(2'd1, 1'b1, 10'h100, 0, 0, "");
    tmr_pulse[0] = 1'b1;
    req_valid = 1'b1; req_op = 2'd2; req_sel = 1'b0; req_wdata = 10'h000; req_wmask = 10'h100;
    exp_q.push_back(10'h000); tag_q.push_back("R12 atomic old pending");
    @(negedge clk);
    tmr_pulse = '0; req_valid = 1'b0;
    irq_is("R12 atomic first", 1'b0, 0);
    @(negedge clk);
    irq_is("R12 event after", 1'b1, 4'd8);

    // R12 hardware mask clear coinciding with atomic on mask
    tmr_pulse[1] = 1'b1; @(negedge clk); tmr_pulse = '0;
    irq_is("R12 setup", 1'b1, 4'd8);
    cfg_mask_clr = 1'b1;
    ack_valid = 1'b1; ack_type = 2'd0; ack_idx = 4'd8;
    req_valid = 1'b1; req_op = 2'd2; req_sel = 1'b1; req_wdata = 10'h200; req_wmask = 10'h300;
    exp_q.push_back(10'h100); tag_q.push_back("R12 atomic old mask");
    @(negedge clk);
    ack_valid = 1'b0; req_valid = 1'b0;
    irq_is("R12 mask written first", 1'b1, 4'd9);
    @(negedge clk);
    irq_is("R12 mask clear after", 1'b0, 0);
    cfg_mask_clr = 1'b0;
    regop(2'd0, 1'b1, 0, 0, 10'h000, "R12 mask final");
    regop(2'd1, 1'b0, 10'h000, 0, 0, "");

    // mixed mode: R5 R7 R8
    cfg_mode = 2'd1;
    regop(2'd1, 1'b1, 10'h3FF, 0, 0, "");
    regop(2'd0, 1'b1, 0, 0, 10'h3E1, "R7 mixed mask reserved");
    chk("R8 mixed global on", int'(xirq_en), 1);
    regop(2'd1, 1'b1, 10'h3E0, 0, 0, "");
    chk("R8 mixed global off", int'(xirq_en), 0);
    pin_pulse(1); repeat (4) @(negedge clk);
    regop(2'd0, 1'b0, 0, 0, 10'h000, "R5 mixed pin ignored");
    regop(2'd1, 1'b0, 10'h3FF, 0, 0, "");
    regop(2'd0, 1'b0, 0, 0, 10'h3E0, "R5 mixed write reserved");
    regop(2'd1, 1'b0, 10'h000, 0, 0, "");

    // expanded mode
    cfg_mode = 2'd2;
    regop(2'd1, 1'b1, 10'h3FF, 0, 0, "");
    regop(2'd0, 1'b1, 0, 0, 10'h301, "R7 expanded mask reserved");
    chk("R8 expanded global on", int'(xirq_en), 1);
    regop(2'd2, 1'b0, 10'h0FF, 10'h0FF, 10'h000, "R5 expanded atomic old");
    pin_pulse(6); repeat (4) @(negedge clk);
    regop(2'd0, 1'b0, 0, 0, 10'h000, "R5 expanded reserved kept");
    irq_is("R5 expanded no request", 1'b0, 0);

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      vectors++; errs++;
      $display("FAIL R13: %0d reads unanswered, expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule